// File: doc/BRIEF.md
# Bus-Master IDE DMA Register Window

This block holds the software-visible registers of a two-channel bus-master IDE DMA controller. It decodes a 16-byte window on a simple register bus. Each access carries a 4-bit byte offset, a size code, a read strobe or a write strobe, and right-justified data. Each channel has three registers: a command register, a status register, and a 32-bit descriptor-table base.

The DMA engine sits outside this block. The block gives it the run and direction bits and the descriptor base for each channel. It also gives one-cycle start and stop pulses. The engine sends back one-cycle set pulses for the active, error and interrupt flags. This block keeps those flags so that software can read them and clear them.

Top module: `bmide_regs`

## Requirements
- R1: Channel 0 occupies offsets 0..7 and channel 1 occupies offsets 8..15. Within each channel slice, offset 0 is the command register, offset 2 is the status register, and offsets 4..7 are the descriptor base, with byte lane = offset bits [1:0].
- R2: A byte read of offset 1 or 3 in a channel slice returns 0x000000FF. A byte write to either offset changes no register.
- R3: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = reserved. Read data is right-justified and the bits above the access width read 0. A command or status access that is not a single byte has two outcomes. A read returns 0x0000FFFF for size 1, 0xFFFFFFFF for size 2 and 0 for size 3. A write is dropped.
- R4: The status byte layout is: bit 0 active, bit 1 error, bit 2 interrupt, and bits 6 and 5 plain read/write. All other status bits read 0. A status byte write loads bits 6 and 5 from the data.
- R5: Error and interrupt are cleared by writing 1 to their bit. Writing 0 leaves them unchanged. An engine set pulse sets the flag on the next edge. If a set pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R6: A status write never changes the active bit. The active bit is set in two cases: by a command write that takes bit 0 from 0 to 1, and by the engine's set pulse. A command write that takes bit 0 from 1 to 0 clears it, and this clear wins over a set pulse in the same cycle.
- R7: The command byte stores bit 0 as run and bit 3 as direction. Both are driven on `dma_run` and `dma_dir`. All other command bits read 0.
- R8: A command write that takes run from 0 to 1 produces a one-cycle start pulse in the cycle after the write. A command write that takes run from 1 to 0 produces a one-cycle stop pulse in the same cycle position.
- R9: The descriptor base takes byte, halfword and word writes. A halfword uses lane pair {offset[1],0} and a word uses all lanes. Reads follow the same lanes, and bits 1:0 always read 0.
- R10: Reset clears all command, status and base registers and all pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset in the window |
| bus_size | input | 2 | Access size code |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, right-justified |
| bus_rdata | output | 32 | Read data, right-justified, 0 when not reading |
| set_act | input | 2 | Engine pulse, set active flag per channel |
| set_err | input | 2 | Engine pulse, set error flag per channel |
| set_irq | input | 2 | Engine pulse, set interrupt flag per channel |
| dma_run | output | 2 | Run bit per channel |
| dma_dir | output | 2 | Direction bit per channel |
| start_pulse | output | 2 | One-cycle start per channel |
| stop_pulse | output | 2 | One-cycle stop per channel |
| desc_base0 | output | 32 | Channel 0 descriptor base |
| desc_base1 | output | 32 | Channel 1 descriptor base |

## Verification
The embedded assertions check four things on every cycle:
- a start or stop pulse agrees with the active flag;
- a set pulse always leaves its flag raised;
- a status write alone leaves the active bit alone;
- a wide write to a command register leaves run and direction unchanged.

Only the bench scenarios can show the rest: the byte-lane placement of the descriptor base, the all-ones read patterns, the exact status bit masks, and the independence of the two channel slices.

// File: rtl/bmide_regs.sv
module bmide_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  set_act,
  input  logic [1:0]  set_err,
  input  logic [1:0]  set_irq,
  output logic [1:0]  dma_run,
  output logic [1:0]  dma_dir,
  output logic [1:0]  start_pulse,
  output logic [1:0]  stop_pulse,
  output logic [31:0] desc_base0,
  output logic [31:0] desc_base1
);
  localparam int NCH = 2;

  logic [NCH-1:0] run, dir, act, err, irq;
  logic [1:0]     sflag [NCH];
  logic [31:0]    base  [NCH];

  logic       ch;
  logic       in_base;
  logic [1:0] lane;
  logic       is_byte;
  assign ch      = bus_addr[3];
  assign in_base = bus_addr[2];
  assign lane    = bus_addr[1:0];
  assign is_byte = (bus_size == 2'd0);

  logic [NCH-1:0] cmd_wr, st_wr, base_wr;
  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign cmd_wr[c]  = bus_wr && (ch == c) && !in_base && is_byte && (lane == 2'd0);
    assign st_wr[c]   = bus_wr && (ch == c) && !in_base && is_byte && (lane == 2'd2);
    assign base_wr[c] = bus_wr && (ch == c) && in_base;
  end

  logic [3:0]  be;
  logic [31:0] wfull;
  always_comb begin
    case (bus_size)
      2'd0:    begin be = 4'b0001 << lane; wfull = {4{bus_wdata[7:0]}}; end
      2'd1:    begin be = lane[1] ? 4'b1100 : 4'b0011; wfull = {2{bus_wdata[15:0]}}; end
      2'd2:    begin be = 4'b1111; wfull = bus_wdata; end
      default: begin be = 4'b0000; wfull = bus_wdata; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0; dir <= '0; act <= '0; err <= '0; irq <= '0;
      start_pulse <= '0; stop_pulse <= '0;
      for (int c = 0; c < NCH; c++) begin
        sflag[c] <= '0;
        base[c]  <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        start_pulse[c] <= cmd_wr[c] && bus_wdata[0] && !run[c];
        stop_pulse[c]  <= cmd_wr[c] && !bus_wdata[0] && run[c];
        if (cmd_wr[c]) begin
          run[c] <= bus_wdata[0];
          dir[c] <= bus_wdata[3];
        end
        if (cmd_wr[c] && !bus_wdata[0] && run[c])
          act[c] <= 1'b0;
        else if ((cmd_wr[c] && bus_wdata[0] && !run[c]) || set_act[c])
          act[c] <= 1'b1;
        err[c] <= set_err[c] || (err[c] && !(st_wr[c] && bus_wdata[1]));
        irq[c] <= set_irq[c] || (irq[c] && !(st_wr[c] && bus_wdata[2]));
        if (st_wr[c]) sflag[c] <= bus_wdata[6:5];
        if (base_wr[c])
          for (int b = 0; b < 4; b++)
            if (be[b]) base[c][b*8 +: 8] <= wfull[b*8 +: 8];
      end
    end
  end

  assign dma_run    = run;
  assign dma_dir    = dir;
  assign desc_base0 = {base[0][31:2], 2'b00};
  assign desc_base1 = {base[1][31:2], 2'b00};

  logic [31:0] bval, bshift, rval;
  logic [1:0]  alane;
  assign bval  = ch ? desc_base1 : desc_base0;
  assign alane = (bus_size == 2'd0) ? lane : (bus_size == 2'd1) ? {lane[1], 1'b0} : 2'd0;
  assign bshift = bval >> {alane, 3'b000};

  always_comb begin
    rval = '0;
    if (in_base) begin
      case (bus_size)
        2'd0:    rval = {24'h0, bshift[7:0]};
        2'd1:    rval = {16'h0, bshift[15:0]};
        2'd2:    rval = bshift;
        default: rval = '0;
      endcase
    end else begin
      case (bus_size)
        2'd0: case (lane)
          2'd0:    rval = {24'h0, 4'b0, dir[ch], 2'b0, run[ch]};
          2'd2:    rval = {24'h0, 1'b0, sflag[ch], 2'b0, irq[ch], err[ch], act[ch]};
          default: rval = 32'h0000_00FF;
        endcase
        2'd1:    rval = 32'h0000_FFFF;
        2'd2:    rval = 32'hFFFF_FFFF;
        default: rval = '0;
      endcase
    end
  end
  assign bus_rdata = bus_rd ? rval : 32'h0;

  a_r3_wide_cmd_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr[2] && bus_size != 2'd0) |=> ($stable(dma_run) && $stable(dma_dir)));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r8_start_means_active: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[c] |-> (act[c] && !stop_pulse[c]));
    a_r6_stop_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse[c] |-> !act[c]);
    a_r5_err_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_err[c] |=> err[c]);
    a_r5_irq_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_irq[c] |=> irq[c]);
    a_r6_status_write_keeps_active: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == (4'(c) << 3) + 4'd2 && !set_act[c]) |=> $stable(act[c]));
  end
endmodule

// File: tb/bmide_regs_bench.sv
module bmide_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  set_act = '0, set_err = '0, set_irq = '0;
  logic [1:0]  dma_run, dma_dir, start_pulse, stop_pulse;
  logic [31:0] desc_base0, desc_base1;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bmide_regs u_bmide_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .set_act(set_act), .set_err(set_err), .set_irq(set_irq),
    .dma_run(dma_run), .dma_dir(dma_dir), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .desc_base0(desc_base0), .desc_base1(desc_base1));

  // entry: [38] 1=read-and-compare 0=write, [37:36] size, [35:32] offset, [31:0] data or expected
  localparam int NV = 25;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 2'd0, 4'd4,  32'h7B}, {1'b0, 2'd0, 4'd5, 32'h56},
    {1'b0, 2'd0, 4'd6,  32'h34}, {1'b0, 2'd0, 4'd7, 32'h12},
    {1'b1, 2'd2, 4'd4,  32'h12345678}, {1'b1, 2'd0, 4'd5, 32'h56},
    {1'b0, 2'd1, 4'd14, 32'hBEEF}, {1'b0, 2'd1, 4'd12, 32'hCAFF},
    {1'b1, 2'd2, 4'd12, 32'hBEEFCAFC}, {1'b1, 2'd1, 4'd14, 32'hBEEF},
    {1'b1, 2'd2, 4'd0,  32'hFFFFFFFF}, {1'b1, 2'd1, 4'd2, 32'h0000FFFF},
    {1'b1, 2'd0, 4'd1,  32'hFF}, {1'b1, 2'd0, 4'd11, 32'hFF},
    {1'b0, 2'd0, 4'd0,  32'hFF}, {1'b1, 2'd0, 4'd0, 32'h09},
    {1'b0, 2'd0, 4'd2,  32'hFF}, {1'b1, 2'd0, 4'd2, 32'h61},
    {1'b0, 2'd2, 4'd0,  32'h0},  {1'b1, 2'd0, 4'd0, 32'h09},
    {1'b0, 2'd0, 4'd10, 32'h20}, {1'b0, 2'd0, 4'd8, 32'h08},
    {1'b1, 2'd0, 4'd10, 32'h20}, {1'b0, 2'd0, 4'd0, 32'h00},
    {1'b1, 2'd0, 4'd2,  32'h60}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [1:0] s, input logic [31:0] e);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_rd = 1'b1;
    #2;
    chk(req, bus_rdata, e);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd("R10 cmd0", 4'd0, 2'd0, 32'h0);
    rd("R10 stat1", 4'd10, 2'd0, 32'h0);
    rd("R10 base1", 4'd12, 2'd2, 32'h0);
    chk("R10 outputs", {24'h0, dma_run, dma_dir, start_pulse, stop_pulse}, 32'h0);

    // R1 R2 R3 R4 R7 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][38]) rd($sformatf("R1/R2/R3/R4/R7/R9 vec%0d", i), VEC[i][35:32], VEC[i][37:36], VEC[i][31:0]);
      else wr(VEC[i][35:32], VEC[i][37:36], VEC[i][31:0]);
    end
    chk("R9 desc_base0", desc_base0, 32'h12345678);
    chk("R7 dir", {30'h0, dma_dir}, 32'h2);
    wr(4'd1, 2'd0, 32'hAA);
    rd("R2 ignored write", 4'd0, 2'd0, 32'h00);

    // R8 start pulse timing
    wr(4'd0, 2'd0, 32'h01);
    chk("R8 start", {30'h0, start_pulse}, 32'h1);
    chk("R8 no stop", {30'h0, stop_pulse}, 32'h0);
    @(negedge clk);
    chk("R8 one cycle", {30'h0, start_pulse}, 32'h0);
    rd("R6 act set by start", 4'd2, 2'd0, 32'h61);
    wr(4'd2, 2'd0, 32'h00);
    rd("R4 R6 status write keeps act", 4'd2, 2'd0, 32'h01);

    // R5 set and clear
    @(negedge clk); set_err = 2'b01; set_irq = 2'b01;
    @(negedge clk); set_err = '0; set_irq = '0;
    rd("R5 set", 4'd2, 2'd0, 32'h07);
    wr(4'd2, 2'd0, 32'h02);
    rd("R5 w1c err", 4'd2, 2'd0, 32'h05);
    @(negedge clk);
    bus_addr = 4'd2; bus_size = 2'd0; bus_wdata = 32'h04; bus_wr = 1'b1; set_irq = 2'b01;
    @(negedge clk);
    bus_wr = 1'b0; set_irq = '0;
    rd("R5 set beats clear", 4'd2, 2'd0, 32'h05);
    wr(4'd2, 2'd0, 32'h04);
    rd("R5 w1c irq", 4'd2, 2'd0, 32'h01);

    // R6 stop beats engine set, R8 stop pulse
    @(negedge clk);
    bus_addr = 4'd0; bus_size = 2'd0; bus_wdata = 32'h00; bus_wr = 1'b1; set_act = 2'b01;
    @(negedge clk);
    bus_wr = 1'b0; set_act = '0;
    chk("R8 stop", {30'h0, stop_pulse}, 32'h1);
    rd("R6 stop wins", 4'd2, 2'd0, 32'h00);

    // R6 engine set on channel 1, R1 independence
    @(negedge clk); set_act = 2'b10;
    @(negedge clk); set_act = '0;
    rd("R6 engine act ch1", 4'd10, 2'd0, 32'h21);
    rd("R1 ch0 untouched", 4'd2, 2'd0, 32'h00);
    wr(4'd10, 2'd1, 32'hFFFF);
    rd("R3 wide status write dropped", 4'd10, 2'd0, 32'h21);
    rd("R3 reserved size read", 4'd8, 2'd3, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule